// File: doc/BRIEF.md
# Edge-Selectable Dual Input Capture

This block sits beside a free-running timer and watches one external input pin. When the pin shows the configured kind of transition, the block copies the timer's current count into a capture register. There are two capture slots, filled in order. After both are full, further transitions are ignored until software rearms the sequence. Software rearms it either by clearing the capture status, or by moving the edge selection from "off" to any active setting.

A configuration write strobe loads three settings together: the pin direction, the edge selection and the event slot. The event slot says whether the one-cycle capture event pulse follows the first capture or the second. The pin is asynchronous. It passes through a synchronizer before edge detection, so captures lag the pin by a fixed number of clocks.

Top module: `edge_capture_unit`

## Requirements
- R1: While `rst` is high and after it falls, both capture outputs read 0 and the event output is low until a capture happens.
- R2: The edge selection is 2 bits. 0 means off (no capture), 1 means rising only, 2 means falling only, 3 means either edge. A transition of the wrong kind changes nothing.
- R3: No capture happens while the registered direction setting marks the pin as an output (`cfg_pin_in_i` = 0).
- R4: The first qualifying edge fills `cap_first_o` and the second fills `cap_second_o`. After two captures, every further edge leaves both outputs unchanged.
- R5: With the event slot setting at 0, `cap_evt_o` is high for exactly one cycle, in the cycle in which the first capture becomes visible. The second capture gives no pulse.
- R6: With the event slot setting at 1, the pulse follows the second capture only.
- R7: A `stat_clr_i` strobe sets the capture count to zero. The next qualifying edge fills `cap_first_o` again.
- R8: A configuration write that moves the edge selection from 0 to a non-zero value sets the capture count to zero. A write between two non-zero values keeps the count.
- R9: The pin goes through two synchronizer flops. A pin change set up before clock edge k shows in the capture outputs after edge k+2, and not before it.
- R10: The stored value is the `count_i` value present in the cycle that ends with edge k+2.
- R11: If `stat_clr_i` and a detected edge fall in the same cycle, the clear wins. That edge is not captured and produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | Asynchronous pin to watch |
| count_i | input | CNT_W | Live value of the companion timer |
| cfg_wr_i | input | 1 | Loads the three configuration fields below |
| cfg_pin_in_i | input | 1 | 1: pin is an input, captures allowed |
| cfg_edge_i | input | 2 | Edge selection (0 off, 1 rise, 2 fall, 3 both) |
| cfg_on_second_i | input | 1 | 0: event after first capture, 1: after second |
| stat_clr_i | input | 1 | Clears capture status and rearms the sequence |
| cap_first_o | output | CNT_W | First capture slot |
| cap_second_o | output | CNT_W | Second capture slot |
| cap_evt_o | output | 1 | One-cycle capture event pulse |

## Verification
The assertions check several properties on every cycle. The capture count never exceeds two. Both slots stay frozen when the sequence is full, when the direction is output, or when the edge selection is off. Every event pulse comes from a capture and lands on the configured slot. A clear or a rearming configuration write always leaves the count at zero. The bench scenarios cover what the assertions do not: the exact synchronizer latency, which counter value gets stored, the rising, falling and both-edge filters, and the clear-versus-edge collision.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int CAP_SLOTS = 2;
  localparam int SLOT_W    = $clog2(CAP_SLOTS + 1);

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_sel_e;
endpackage

// File: rtl/cap_pin_sync.sv
module cap_pin_sync
  import cap_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      pin_i,
  input  edge_sel_e sel_i,
  output logic      hit_o
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] the previous one
  logic [STAGES:0] sh;
  logic            lvl, prev, rise, fall;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], pin_i};
  end

  assign lvl  = sh[STAGES-1];
  assign prev = sh[STAGES];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

  always_comb begin
    unique case (sel_i)
      EDGE_RISE: hit_o = rise;
      EDGE_FALL: hit_o = fall;
      EDGE_ANY:  hit_o = rise | fall;
      default:   hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cap_sequencer.sv
module cap_sequencer
  import cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              hit_i,
  input  logic              enable_i,
  input  logic              clr_i,
  input  logic              rearm_i,
  input  logic              second_i,
  output logic              take_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              evt_o
);
  logic [SLOT_W-1:0] cnt;
  logic              room;
  logic [SLOT_W-1:0] evt_slot;

  assign room     = (cnt < SLOT_W'(CAP_SLOTS));
  assign take_o   = hit_i & enable_i & room & ~clr_i;
  assign slot_o   = cnt;
  assign evt_slot = second_i ? SLOT_W'(1) : SLOT_W'(0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      evt_o <= 1'b0;
    end else begin
      evt_o <= take_o && (cnt == evt_slot);
      if (clr_i || rearm_i) cnt <= '0;
      else if (take_o)      cnt <= cnt + SLOT_W'(1);
    end
  end
endmodule

// File: rtl/cap_store.sv
module cap_store
  import cap_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [W-1:0]      value_i,
  output logic [W-1:0]      slot0_o,
  output logic [W-1:0]      slot1_o
);
  logic [W-1:0] regs [CAP_SLOTS];

  for (genvar g = 0; g < CAP_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                                    regs[g] <= '0;
      else if (take_i && slot_i == SLOT_W'(g))    regs[g] <= value_i;
    end
  end

  assign slot0_o = regs[0];
  assign slot1_o = regs[1];
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import cap_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             cfg_wr_i,
  input  logic             cfg_pin_in_i,
  input  logic [1:0]       cfg_edge_i,
  input  logic             cfg_on_second_i,
  input  logic             stat_clr_i,
  output logic [CNT_W-1:0] cap_first_o,
  output logic [CNT_W-1:0] cap_second_o,
  output logic             cap_evt_o
);
  edge_sel_e         mode_q;
  logic              dir_q, second_q;
  logic              hit, take, rearm;
  logic [SLOT_W-1:0] seq_cnt;

  assign rearm = cfg_wr_i && (mode_q == EDGE_OFF) && (edge_sel_e'(cfg_edge_i) != EDGE_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= EDGE_OFF;
      dir_q    <= 1'b0;
      second_q <= 1'b0;
    end else if (cfg_wr_i) begin
      mode_q   <= edge_sel_e'(cfg_edge_i);
      dir_q    <= cfg_pin_in_i;
      second_q <= cfg_on_second_i;
    end
  end

  cap_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_i(pin_i), .sel_i(mode_q), .hit_o(hit)
  );

  cap_sequencer u_seq (
    .clk(clk), .rst(rst), .hit_i(hit), .enable_i(dir_q), .clr_i(stat_clr_i),
    .rearm_i(rearm), .second_i(second_q), .take_o(take), .slot_o(seq_cnt),
    .evt_o(cap_evt_o)
  );

  cap_store #(.W(CNT_W)) u_store (
    .clk(clk), .rst(rst), .take_i(take), .slot_i(seq_cnt), .value_i(count_i),
    .slot0_o(cap_first_o), .slot1_o(cap_second_o)
  );
endmodule

// File: rtl/cap_checker.sv
module cap_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         dir_q,
  input logic [1:0]   mode_q,
  input logic         second_q,
  input logic [1:0]   cnt,
  input logic         take,
  input logic         stat_clr_i,
  input logic         cfg_wr_i,
  input logic [1:0]   cfg_edge_i,
  input logic [W-1:0] cap_first_o,
  input logic [W-1:0] cap_second_o,
  input logic         cap_evt_o
);
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
    cnt <= 2'd2);
  assert_full_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt == 2'd2) |=> ($stable(cap_first_o) && $stable(cap_second_o)));
  assert_dir_gate_R3: assert property (@(posedge clk) disable iff (rst)
    !dir_q |=> ($stable(cap_first_o) && $stable(cap_second_o)));
  assert_off_gate_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'd0) |=> ($stable(cap_first_o) && $stable(cap_second_o)));
  assert_evt_from_take_R5: assert property (@(posedge clk) disable iff (rst)
    cap_evt_o |-> $past(take));
  assert_evt_slot_R6: assert property (@(posedge clk) disable iff (rst)
    cap_evt_o |-> (cnt == ($past(second_q) ? 2'd2 : 2'd1)));
  assert_clr_zero_R7: assert property (@(posedge clk) disable iff (rst)
    stat_clr_i |=> (cnt == 2'd0));
  assert_rearm_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr_i && mode_q == 2'd0 && cfg_edge_i != 2'd0) |=> (cnt == 2'd0));
endmodule

bind edge_capture_unit cap_checker #(.W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .dir_q(dir_q), .mode_q(mode_q), .second_q(second_q),
  .cnt(seq_cnt), .take(take), .stat_clr_i(stat_clr_i), .cfg_wr_i(cfg_wr_i),
  .cfg_edge_i(cfg_edge_i), .cap_first_o(cap_first_o),
  .cap_second_o(cap_second_o), .cap_evt_o(cap_evt_o)
);

// File: tb/sim_edge_capture_unit.sv
module sim_edge_capture_unit;
  logic        clk = 0;
  logic        rst = 1;
  logic        pin = 0;
  logic [31:0] cnt_in = 0;
  logic        cfg_wr = 0, cfg_in = 0, cfg_sec = 0, clr = 0;
  logic [1:0]  cfg_edge = 0;
  logic [31:0] c1, c2;
  logic        evt;
  int          n_run = 0, n_fail = 0, n_evt = 0;

  always #10 clk = ~clk;

  edge_capture_unit u0 (
    .clk(clk), .rst(rst), .pin_i(pin), .count_i(cnt_in), .cfg_wr_i(cfg_wr),
    .cfg_pin_in_i(cfg_in), .cfg_edge_i(cfg_edge), .cfg_on_second_i(cfg_sec),
    .stat_clr_i(clr), .cap_first_o(c1), .cap_second_o(c2), .cap_evt_o(evt)
  );

  always @(posedge clk) if (!rst && evt) n_evt++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; pin = 0; clr = 0; cfg_wr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0; n_evt = 0;
  endtask

  task automatic cfg(input logic din, input logic [1:0] e, input logic sec);
    @(negedge clk); cfg_wr = 1; cfg_in = din; cfg_edge = e; cfg_sec = sec;
    @(negedge clk); cfg_wr = 0;
  endtask

  // drive pin and counter, then let synchronizer, capture and event settle
  task automatic step(input logic p, input logic [31:0] v);
    @(negedge clk); pin = p; cnt_in = v;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  typedef struct packed {
    logic        clr;
    logic        p;
    logic [31:0] v;
    logic [31:0] e1;
    logic [31:0] e2;
    logic [3:0]  ev;
  } vec_t;

  // mode both edges, event after second capture (R4, R6, R7)
  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b1, 32'h11, 32'h11, 32'h0,  4'd0},
    '{1'b0, 1'b0, 32'h22, 32'h11, 32'h22, 4'd1},
    '{1'b0, 1'b1, 32'h33, 32'h11, 32'h22, 4'd1},
    '{1'b1, 1'b1, 32'h44, 32'h11, 32'h22, 4'd1},
    '{1'b0, 1'b0, 32'h55, 32'h55, 32'h22, 4'd1},
    '{1'b0, 1'b1, 32'h66, 32'h55, 32'h66, 4'd2}
  };

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    join_none

    // R1 reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 first in reset", c1, 0);
    chk("R1 event in reset", {31'b0, evt}, 0);
    do_reset();
    chk("R1 second after reset", c2, 0);

    // vector table: R4 R6 R7
    cfg(1, 2'd3, 1);
    for (int i = 0; i < 6; i++) begin
      if (VECS[i].clr) begin
        @(negedge clk); clr = 1; @(negedge clk); clr = 0;
      end else begin
        step(VECS[i].p, VECS[i].v);
      end
      chk($sformatf("R4/R6/R7 vec%0d first", i), c1, VECS[i].e1);
      chk($sformatf("R4/R6/R7 vec%0d second", i), c2, VECS[i].e2);
      chk($sformatf("R6 vec%0d events", i), n_evt, {28'b0, VECS[i].ev});
    end

    // R3 direction output blocks capture
    do_reset();
    cfg(0, 2'd3, 0);
    step(1, 32'hA1); step(0, 32'hA2);
    chk("R3 first", c1, 0); chk("R3 second", c2, 0); chk("R3 events", n_evt, 0);

    // R2 off mode
    do_reset();
    cfg(1, 2'd0, 0);
    step(1, 32'hB1); step(0, 32'hB2);
    chk("R2 off first", c1, 0); chk("R2 off events", n_evt, 0);

    // R2 rising only, R5 event after first capture
    do_reset();
    cfg(1, 2'd1, 0);
    step(1, 32'hC1);
    chk("R2 rise first", c1, 32'hC1); chk("R5 event after first", n_evt, 1);
    step(0, 32'hC2);
    chk("R2 rise ignores fall", c2, 0);
    step(1, 32'hC3);
    chk("R2 rise second", c2, 32'hC3); chk("R5 no event on second", n_evt, 1);

    // R2 falling only
    do_reset();
    cfg(1, 2'd2, 0);
    step(1, 32'hD1);
    chk("R2 fall ignores rise", c1, 0);
    step(0, 32'hD2);
    chk("R2 fall first", c1, 32'hD2);

    // R8 rearm rules
    do_reset();
    cfg(1, 2'd3, 0);
    step(1, 32'hE1); step(0, 32'hE2);
    cfg(1, 2'd1, 0);
    step(1, 32'hE3);
    chk("R8 active-to-active keeps count", c1, 32'hE1);
    cfg(1, 2'd0, 0);
    cfg(1, 2'd3, 0);
    step(0, 32'hE4);
    chk("R8 off-to-active rearms", c1, 32'hE4);
    chk("R8 second kept", c2, 32'hE2);

    // R9 latency and R10 sampled value
    do_reset();
    cfg(1, 2'd1, 0);
    @(negedge clk); pin = 1; cnt_in = 32'h1;
    @(negedge clk); cnt_in = 32'h2;
    @(negedge clk); cnt_in = 32'h3;
    chk("R9 not yet after k+1", c1, 0);
    @(negedge clk); cnt_in = 32'h4;
    chk("R9 visible after k+2", c1, 32'h3);
    chk("R10 value from detect cycle", c1, 32'h3);
    chk("R5 pulse same cycle", {31'b0, evt}, 1);
    @(negedge clk);
    chk("R5 pulse one cycle", {31'b0, evt}, 0);

    // R11 clear collides with detected edge
    do_reset();
    cfg(1, 2'd3, 0);
    step(1, 32'hF1);
    @(negedge clk); pin = 0; cnt_in = 32'hF2;
    @(negedge clk);
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    repeat (2) @(negedge clk);
    chk("R11 edge dropped", c2, 0);
    chk("R11 first unchanged", c1, 32'hF1);
    chk("R11 no event", n_evt, 1);
    step(1, 32'hF3);
    chk("R11/R7 next goes to first", c1, 32'hF3);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule